// File: doc/BRIEF.md
# Vector Length State Register Unit

This unit holds the working state of a register-tagging parallel loop engine: the upper bound on loop length (the maximum length), the active loop length, a 5-bit table-window configuration, and the source and destination element positions of a loop that was interrupted. Software reaches this state through three control registers: the length register, the maximum-length register and a packed state word. The packed word saves or restores everything in one access during a context switch.

An access is one cycle with `acc_i` high. It names a register (`sel_i`) and an operation (`op_i`): a read, a write of a full-width register value, or a write of a 5-bit immediate. The value the instruction returns to its destination register appears one cycle later on `ret_data_o`, qualified by `ret_valid_o`. A register-path write of zero to either length register is refused and reported by a one-cycle `exc_o` pulse. These are plain control pins. There is no handshake and no back-pressure: the unit takes one access in every cycle.

Encodings: `op_i` 0 = read, 1 = register write, 2 = immediate write, 3 = no operation. `sel_i` 0 = length, 1 = maximum length, 2 = state word, 3 = unassigned.

Top module: `vlst_unit`

## Requirements
- R1: After reset the maximum length is 1, the length is 1, both element positions are 0, the configuration is 5'b11111 (disabled), `ret_valid_o` is 0 and `exc_o` is 0.
- R2: A register write to the length register sets the length to MIN(value, maximum length). The value returned one cycle later is that new length, not the previous one.
- R3: An immediate write stores immediate+1. For the length register this is then clamped as in R2. For the maximum-length register it is clamped as in R5. For the state word, the zero-extended immediate is decoded as a packed word (R7).
- R4: A register write of zero to the length or maximum-length register leaves all state unchanged, returns no value, and raises `exc_o` for exactly one cycle.
- R5: The maximum length always stays within 1..XLEN and the length within 1..maximum length. A maximum-length write that lowers the bound below the current length also lowers the length.
- R6: Reading the state word returns maximum length-1 in bits 5:0, length-1 in bits 11:6, the source position in bits 17:12, the destination position in bits 23:18 and the configuration in bits 28:24. All other bits read as 0.
- R7: A state-word write decodes the fields of R6, adds 1 to both length fields, and clamps in this order: maximum length, then length against the new maximum, then positions against the new length.
- R8: Both element positions are held within 0..length-1 after every write. This applies both when a state word sets them and when a length change shrinks the range.
- R9: An access whose destination is register zero (`dest_x0_i`) returns no value (`ret_valid_o` stays 0), but any write it carries still takes effect.
- R10: `cfg_o` presents the stored configuration (window start in bits 2:0, window size code in bits 4:3). `sv_off_o` is 1 exactly when the configuration is 5'b11111.
- R11: Reads of the length and maximum-length registers return the exact values, not minus one. A maximum-length write and a state-word write return the previous contents.
- R12: An access to the unassigned register (`sel_i` = 3) reads as 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_i | input | 1 | Access strobe, one access per cycle |
| op_i | input | 2 | Operation: 0 read, 1 register write, 2 immediate write, 3 none |
| sel_i | input | 2 | Register: 0 length, 1 maximum length, 2 state word, 3 unassigned |
| dest_x0_i | input | 1 | Destination is register zero: discard the return value |
| wdata_i | input | XLEN | Register-path write value |
| imm_i | input | 5 | Immediate-path write value |
| ret_valid_o | output | 1 | Return value valid, one cycle after the access |
| ret_data_o | output | XLEN | Value for the destination register |
| exc_o | output | 1 | Illegal-value exception pulse |
| mvl_o | output | LW | Current maximum length (LW = clog2(XLEN+1)) |
| vl_o | output | LW | Current length |
| src_off_o | output | 6 | Source element position |
| dst_off_o | output | 6 | Destination element position |
| cfg_o | output | 5 | Table-window configuration |
| sv_off_o | output | 1 | Configuration marks the extension disabled |

## Verification
The bench builds the unit with XLEN = 32, so the 6-bit length fields of the state word can request 64. This exercises the clamp of the maximum length at XLEN and the clamp of the length against it. A 5-bit immediate of 31 reaches exactly XLEN. With this width, both offset clamps and the shrink of the positions after a length write can be reached with small values. The run also brings the exception and the discarded-return paths within reach.

// File: rtl/vlst_pkg.sv
package vlst_pkg;
  localparam int FW      = 6;               // width of each packed length/position field
  localparam int CW      = 5;               // configuration width
  localparam int STATE_W = 4 * FW + CW;     // packed state word width

  typedef enum logic [1:0] {SEL_VL = 2'd0, SEL_MVL = 2'd1, SEL_STATE = 2'd2, SEL_NONE = 2'd3} csr_sel_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WREG = 2'd1, OP_WIMM = 2'd2, OP_NOP = 2'd3} csr_op_e;
endpackage

// File: rtl/vlst_clamp.sv
module vlst_clamp
  import vlst_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LW   = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] req_mvl_i,
  input  logic [XLEN-1:0] req_vl_i,
  input  logic [FW-1:0]   req_src_i,
  input  logic [FW-1:0]   req_dst_i,
  output logic [LW-1:0]   mvl_o,
  output logic [LW-1:0]   vl_o,
  output logic [FW-1:0]   src_o,
  output logic [FW-1:0]   dst_o
);
  localparam logic [XLEN-1:0] CAP = XLEN'(XLEN);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [XLEN-1:0] mvl_w, vl_w, lim_w, src_w, dst_w;

  // Stage order: bound, then length against bound, then positions against length.
  always_comb begin
    mvl_w = (req_mvl_i > CAP)   ? CAP   : req_mvl_i;
    vl_w  = (req_vl_i  > mvl_w) ? mvl_w : req_vl_i;
    lim_w = vl_w - ONE;
    src_w = {{(XLEN-FW){1'b0}}, req_src_i};
    dst_w = {{(XLEN-FW){1'b0}}, req_dst_i};
    mvl_o = mvl_w[LW-1:0];
    vl_o  = vl_w[LW-1:0];
    src_o = (src_w > lim_w) ? lim_w[FW-1:0] : req_src_i;
    dst_o = (dst_w > lim_w) ? lim_w[FW-1:0] : req_dst_i;
  end
endmodule

// File: rtl/vlst_pack.sv
module vlst_pack
  import vlst_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LW   = $clog2(XLEN + 1)
) (
  // pack direction: stored state to minus-one word
  input  logic [LW-1:0]      mvl_i,
  input  logic [LW-1:0]      vl_i,
  input  logic [FW-1:0]      src_i,
  input  logic [FW-1:0]      dst_i,
  input  logic [CW-1:0]      cfg_i,
  output logic [STATE_W-1:0] word_o,
  // unpack direction: minus-one word to requested values
  input  logic [STATE_W-1:0] word_i,
  output logic [XLEN-1:0]    req_mvl_o,
  output logic [XLEN-1:0]    req_vl_o,
  output logic [FW-1:0]      req_src_o,
  output logic [FW-1:0]      req_dst_o,
  output logic [CW-1:0]      req_cfg_o
);
  localparam logic [LW-1:0]   ONE_L = LW'(1);
  localparam logic [XLEN-1:0] ONE_X = XLEN'(1);

  logic [LW-1:0] mvl_m1, vl_m1;

  always_comb begin
    mvl_m1 = mvl_i - ONE_L;
    vl_m1  = vl_i - ONE_L;
    word_o = {cfg_i, dst_i, src_i, vl_m1[FW-1:0], mvl_m1[FW-1:0]};
  end

  always_comb begin
    req_mvl_o = {{(XLEN-FW){1'b0}}, word_i[FW-1:0]} + ONE_X;
    req_vl_o  = {{(XLEN-FW){1'b0}}, word_i[2*FW-1:FW]} + ONE_X;
    req_src_o = word_i[3*FW-1:2*FW];
    req_dst_o = word_i[4*FW-1:3*FW];
    req_cfg_o = word_i[STATE_W-1:4*FW];
  end
endmodule

// File: rtl/vlst_unit.sv
module vlst_unit
  import vlst_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LW  = $clog2(XLEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      sel_i,
  input  logic            dest_x0_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [4:0]      imm_i,
  output logic            ret_valid_o,
  output logic [XLEN-1:0] ret_data_o,
  output logic            exc_o,
  output logic [LW-1:0]   mvl_o,
  output logic [LW-1:0]   vl_o,
  output logic [5:0]      src_off_o,
  output logic [5:0]      dst_off_o,
  output logic [4:0]      cfg_o,
  output logic            sv_off_o
);
  localparam logic [XLEN-1:0] ONE_X   = XLEN'(1);
  localparam logic [LW-1:0]   RST_LEN = LW'(1);
  localparam logic [CW-1:0]   CFG_OFF = '1;

  csr_sel_e sel;
  csr_op_e  op;
  assign sel = csr_sel_e'(sel_i);
  assign op  = csr_op_e'(op_i);

  // architectural state
  logic [LW-1:0] mvl_q, vl_q;
  logic [FW-1:0] src_q, dst_q;
  logic [CW-1:0] cfg_q;

  // packed view of the current state and decode of an incoming word
  logic [STATE_W-1:0] cur_word, in_word;
  logic [XLEN-1:0]    w_mvl, w_vl;
  logic [FW-1:0]      w_src, w_dst;
  logic [CW-1:0]      w_cfg;

  vlst_pack #(.XLEN(XLEN), .LW(LW)) u_pack (
    .mvl_i(mvl_q), .vl_i(vl_q), .src_i(src_q), .dst_i(dst_q), .cfg_i(cfg_q),
    .word_o(cur_word),
    .word_i(in_word),
    .req_mvl_o(w_mvl), .req_vl_o(w_vl), .req_src_o(w_src), .req_dst_o(w_dst),
    .req_cfg_o(w_cfg)
  );

  // write value seen by the length registers
  logic [XLEN-1:0] wval;
  logic            is_write, zero_bad, do_write;

  always_comb begin
    is_write = acc_i && ((op == OP_WREG) || (op == OP_WIMM));
    wval     = (op == OP_WIMM) ? ({{(XLEN-5){1'b0}}, imm_i} + ONE_X) : wdata_i;
    in_word  = (op == OP_WIMM) ? {{(STATE_W-5){1'b0}}, imm_i} : wdata_i[STATE_W-1:0];
    zero_bad = acc_i && (op == OP_WREG) && (wdata_i == '0) &&
               ((sel == SEL_VL) || (sel == SEL_MVL));
    do_write = is_write && !zero_bad && (sel != SEL_NONE);
  end

  // requested (unclamped) values per target register
  logic [XLEN-1:0] req_mvl, req_vl;
  logic [FW-1:0]   req_src, req_dst;
  logic [CW-1:0]   req_cfg;

  always_comb begin
    req_mvl = {{(XLEN-LW){1'b0}}, mvl_q};
    req_vl  = {{(XLEN-LW){1'b0}}, vl_q};
    req_src = src_q;
    req_dst = dst_q;
    req_cfg = cfg_q;
    unique case (sel)
      SEL_VL:    req_vl  = wval;
      SEL_MVL:   req_mvl = wval;
      SEL_STATE: begin
        req_mvl = w_mvl;
        req_vl  = w_vl;
        req_src = w_src;
        req_dst = w_dst;
        req_cfg = w_cfg;
      end
      default: ;
    endcase
  end

  logic [LW-1:0] nxt_mvl, nxt_vl;
  logic [FW-1:0] nxt_src, nxt_dst;

  vlst_clamp #(.XLEN(XLEN), .LW(LW)) u_clamp (
    .req_mvl_i(req_mvl), .req_vl_i(req_vl), .req_src_i(req_src), .req_dst_i(req_dst),
    .mvl_o(nxt_mvl), .vl_o(nxt_vl), .src_o(nxt_src), .dst_o(nxt_dst)
  );

  // value handed back to the destination register
  logic [XLEN-1:0] old_val, ret_val;

  always_comb begin
    unique case (sel)
      SEL_VL:    old_val = {{(XLEN-LW){1'b0}}, vl_q};
      SEL_MVL:   old_val = {{(XLEN-LW){1'b0}}, mvl_q};
      SEL_STATE: old_val = {{(XLEN-STATE_W){1'b0}}, cur_word};
      default:   old_val = '0;
    endcase
    // the length register hands back its new value; the others the old one
    ret_val = (do_write && (sel == SEL_VL)) ? {{(XLEN-LW){1'b0}}, nxt_vl} : old_val;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mvl_q       <= RST_LEN;
      vl_q        <= RST_LEN;
      src_q       <= '0;
      dst_q       <= '0;
      cfg_q       <= CFG_OFF;
      ret_valid_o <= 1'b0;
      ret_data_o  <= '0;
      exc_o       <= 1'b0;
    end else begin
      if (do_write) begin
        mvl_q <= nxt_mvl;
        vl_q  <= nxt_vl;
        src_q <= nxt_src;
        dst_q <= nxt_dst;
        cfg_q <= req_cfg;
      end
      ret_valid_o <= acc_i && (op != OP_NOP) && !zero_bad && !dest_x0_i;
      ret_data_o  <= ret_val;
      exc_o       <= zero_bad;
    end
  end

  assign mvl_o     = mvl_q;
  assign vl_o      = vl_q;
  assign src_off_o = src_q;
  assign dst_off_o = dst_q;
  assign cfg_o     = cfg_q;
  assign sv_off_o  = (cfg_q == CFG_OFF);
endmodule

// File: rtl/vlst_chk.sv
module vlst_chk #(
  parameter int XLEN = 32,
  parameter int LW   = $clog2(XLEN + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acc_i,
  input logic [1:0]      op_i,
  input logic [1:0]      sel_i,
  input logic            dest_x0_i,
  input logic [XLEN-1:0] wdata_i,
  input logic [4:0]      imm_i,
  input logic            ret_valid_o,
  input logic [XLEN-1:0] ret_data_o,
  input logic            exc_o,
  input logic [LW-1:0]   mvl_o,
  input logic [LW-1:0]   vl_o,
  input logic [5:0]      src_off_o,
  input logic [5:0]      dst_off_o,
  input logic [4:0]      cfg_o
);
  localparam logic [LW:0] CAP = (LW+1)'(XLEN);

  assert_len_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, mvl_o} >= 1) && ({1'b0, mvl_o} <= CAP) && (vl_o >= 1) && (vl_o <= mvl_o));

  assert_pos_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, src_off_o} < {1'b0, vl_o}) && ({1'b0, dst_off_o} < {1'b0, vl_o}));

  assert_exc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> ($stable(mvl_o) && $stable(vl_o) && $stable(cfg_o) && !ret_valid_o));

  assert_x0_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && dest_x0_i) |=> !ret_valid_o);

  assert_new_len_ret_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && op_i == 2'd1 && sel_i == 2'd0 && wdata_i != '0 && !dest_x0_i)
    |=> (ret_valid_o && ret_data_o == {{(XLEN-LW){1'b0}}, vl_o}));

  assert_imm_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && op_i == 2'd2 && sel_i == 2'd0)
    |=> ({1'b0, vl_o} == ((({2'b0, $past(imm_i)} + 7'd1) > 7'($past(mvl_o)))
                           ? 7'($past(mvl_o)) : ({2'b0, $past(imm_i)} + 7'd1))));

  assert_unassigned_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && sel_i == 2'd3) |=> ($stable(mvl_o) && $stable(vl_o) && $stable(cfg_o) &&
                                  $stable(src_off_o) && $stable(dst_off_o)));
endmodule

bind vlst_unit vlst_chk #(.XLEN(XLEN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .op_i(op_i), .sel_i(sel_i),
  .dest_x0_i(dest_x0_i), .wdata_i(wdata_i), .imm_i(imm_i),
  .ret_valid_o(ret_valid_o), .ret_data_o(ret_data_o), .exc_o(exc_o),
  .mvl_o(mvl_o), .vl_o(vl_o), .src_off_o(src_off_o), .dst_off_o(dst_off_o),
  .cfg_o(cfg_o)
);

// File: tb/test_vlst_unit.sv
`timescale 1ns/1ps
module test_vlst_unit;
  localparam int XLEN = 32;
  localparam int LW   = $clog2(XLEN + 1);
  localparam int NV   = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc = 1'b0;
  logic [1:0]      op = '0, sel = '0;
  logic            x0 = 1'b0;
  logic [XLEN-1:0] wd = '0;
  logic [4:0]      imm = '0;
  logic            ret_v, exc, sv_off;
  logic [XLEN-1:0] ret_d;
  logic [LW-1:0]   mvl, vl;
  logic [5:0]      srco, dsto;
  logic [4:0]      cfg;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  vlst_unit #(.XLEN(XLEN)) i_vlst_unit (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .op_i(op), .sel_i(sel),
    .dest_x0_i(x0), .wdata_i(wd), .imm_i(imm),
    .ret_valid_o(ret_v), .ret_data_o(ret_d), .exc_o(exc),
    .mvl_o(mvl), .vl_o(vl), .src_off_o(srco), .dst_off_o(dsto),
    .cfg_o(cfg), .sv_off_o(sv_off)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  op;
    logic [1:0]  sel;
    logic        x0;
    logic [31:0] wd;
    logic [4:0]  imm;
    logic        ev;
    logic [31:0] er;
    logic        ex;
    logic [6:0]  evl;
    logic [6:0]  emvl;
    logic [5:0]  esrc;
    logic [5:0]  edst;
    logic [4:0]  ecfg;
  } vec_t;

  function automatic vec_t mk(logic [23:0] t, int o, int s, int z, logic [31:0] w, int i,
                              int v, logic [31:0] r, int e, int l, int m, int sr, int ds, int c);
    vec_t x;
    x.tag = t; x.op = 2'(o); x.sel = 2'(s); x.x0 = 1'(z); x.wd = w; x.imm = 5'(i);
    x.ev = 1'(v); x.er = r; x.ex = 1'(e); x.evl = 7'(l); x.emvl = 7'(m);
    x.esrc = 6'(sr); x.edst = 6'(ds); x.ecfg = 5'(c);
    return x;
  endfunction

  // op: 0 read, 1 reg write, 2 imm write; sel: 0 len, 1 max len, 2 state, 3 unassigned
  localparam vec_t VECS [NV] = '{
    mk("R11", 0,0,0, 32'd0,          0, 1, 32'd1,          0,  1,  1, 0,0,31),
    mk("R3 ", 2,1,0, 32'd0,          3, 1, 32'd1,          0,  1,  4, 0,0,31),
    mk("R2 ", 1,0,0, 32'd10,         0, 1, 32'd4,          0,  4,  4, 0,0,31),
    mk("R2 ", 1,0,0, 32'd2,          0, 1, 32'd2,          0,  2,  4, 0,0,31),
    mk("R11", 0,1,0, 32'd0,          0, 1, 32'd4,          0,  2,  4, 0,0,31),
    mk("R5 ", 1,1,0, 32'd100,        0, 1, 32'd4,          0,  2, 32, 0,0,31),
    mk("R3 ", 2,0,0, 32'd0,         31, 1, 32'd32,         0, 32, 32, 0,0,31),
    mk("R4 ", 1,0,0, 32'd0,          0, 0, 32'd0,          1, 32, 32, 0,0,31),
    mk("R4 ", 1,1,0, 32'd0,          0, 0, 32'd0,          1, 32, 32, 0,0,31),
    mk("R5 ", 1,1,0, 32'd5,          0, 1, 32'd32,         0,  5,  5, 0,0,31),
    mk("R9 ", 1,0,1, 32'd3,          0, 0, 32'd0,          0,  3,  5, 0,0,31),
    mk("R6 ", 0,2,0, 32'd0,          0, 1, 32'h1F000084,   0,  3,  5, 0,0,31),
    mk("R7 ", 1,2,0, 32'h0A304189,   0, 1, 32'h1F000084,   0,  7, 10, 4,6,10),
    mk("R6 ", 0,2,0, 32'd0,          0, 1, 32'h0A184189,   0,  7, 10, 4,6,10),
    mk("R8 ", 1,0,0, 32'd3,          0, 1, 32'd3,          0,  3, 10, 2,2,10),
    mk("R8 ", 0,2,0, 32'd0,          0, 1, 32'h0A082089,   0,  3, 10, 2,2,10),
    mk("R7 ", 1,2,0, 32'h1F000FFF,   0, 1, 32'h0A082089,   0, 32, 32, 0,0,31),
    mk("R3 ", 2,2,0, 32'd0,          7, 1, 32'h1F0007DF,   0,  1,  8, 0,0,0),
    mk("R12", 1,3,0, 32'd5,          0, 1, 32'd0,          0,  1,  8, 0,0,0),
    mk("R12", 0,3,0, 32'd0,          0, 1, 32'd0,          0,  1,  8, 0,0,0)
  };

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(logic [1:0] o, logic [1:0] s, logic z, logic [31:0] w, logic [4:0] i);
    @(negedge clk);
    acc = 1'b1; op = o; sel = s; x0 = z; wd = w; imm = i;
    @(negedge clk);
    acc = 1'b0; op = 2'd3; x0 = 1'b0; wd = '0; imm = '0;
  endtask

  task automatic check_state(string tag, int l, int m, int sr, int ds, int c);
    logic [30:0] a, e;
    a = {7'(vl), 7'(mvl), srco, dsto, cfg};
    e = {7'(l), 7'(m), 6'(sr), 6'(ds), 5'(c)};
    check(a == e, tag, "state vl/mvl/src/dst/cfg", 64'(a), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1", 1, 1, 0, 0, 31);
    check(!ret_v && !exc && sv_off, "R1", "ret_valid/exc/sv_off", {61'd0, ret_v, exc, sv_off}, 64'd1);

    // table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic [64:0] a, e;
      v = VECS[k];
      access(v.op, v.sel, v.x0, v.wd, v.imm);
      a = {ret_v, (v.ev ? ret_d : 32'd0), exc, 7'(vl), 7'(mvl), srco, dsto, cfg, 5'd0};
      e = {v.ev, v.er, v.ex, v.evl, v.emvl, v.esrc, v.edst, v.ecfg, 5'd0};
      n_chk++;
      if (a != e) begin
        n_fail++;
        $display("FAIL %s vector %0d: actual %h expected %h", v.tag, k, a, e);
      end
    end

    // R10 configuration 0 after the last state write: enabled
    check(!sv_off && cfg == 5'd0, "R10", "sv_off with cfg 0", {58'd0, sv_off, cfg}, 64'd0);

    // R10 window fields: start 5, size code 2, enabled
    access(2'd1, 2'd2, 1'b0, (32'h15 << 24) | 32'h3, 5'd0);
    check(cfg == 5'h15 && !sv_off, "R10", "cfg fields", {58'd0, sv_off, cfg}, 64'h15);

    // R10 all-ones configuration disables
    access(2'd1, 2'd2, 1'b0, 32'h1F000000, 5'd0);
    check(sv_off == 1'b1, "R10", "sv_off with cfg all ones", 64'(sv_off), 64'd1);

    // R4 exception is a single-cycle pulse
    access(2'd1, 2'd1, 1'b0, 32'd0, 5'd0);
    check(exc == 1'b1, "R4", "exc on zero write", 64'(exc), 64'd1);
    @(negedge clk);
    check(exc == 1'b0, "R4", "exc drops after one cycle", 64'(exc), 64'd0);

    // R9 state-word write to x0 still updates state
    access(2'd1, 2'd2, 1'b1, (32'd2 << 18) | (32'd1 << 12) | (32'd4 << 6) | 32'd9, 5'd0);
    check(ret_v == 1'b0, "R9", "no return to x0", 64'(ret_v), 64'd0);
    check_state("R9", 5, 10, 1, 2, 0);

    // R5 maximum-length write below the length drags the length and positions down
    access(2'd2, 2'd1, 1'b0, 32'd0, 5'd1);
    check(ret_v && ret_d == 32'd10, "R11", "old max length returned", 64'(ret_d), 64'd10);
    check_state("R5", 2, 2, 1, 1, 0);

    // R1 reset mid-run restores reset state
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 1, 1, 0, 0, 31);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule